// File: doc/BRIEF.md
# GPIO Bank Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller that serves up to 128 pins, arranged as 32-bit banks. For each pin, software sets whether the pin is driven or sensed, and sets the level it drives. The drive level can be changed atomically through separate set and clear aliases. Software can also read back the sampled pin level, and can enable a rising-edge interrupt, a falling-edge interrupt or both.

Each detected edge latches a sticky status bit. Software clears a status bit by writing 1 to it. Status bits are ORed into one interrupt request line for each group of 16 pins, so every 32-bit bank drives two request lines.

The register bus has a byte address and 32-bit data. A write takes effect on the clock edge at which it is sampled. Read data is registered: it appears after the sampling edge and holds until the next read. The parameter `NUM_GPIO` sets the number of pins that exist. Register bits, pins and request lines above that count are absent.

Top module: `gpio_bank_ctrl`

The address decoder classifies each access into one register kind from an enumerated set: `REG_DIR`, `REG_OUT`, `REG_SET_OUT`, `REG_CLR_OUT`, `REG_IN`, `REG_SET_RISE`, `REG_CLR_RISE`, `REG_SET_FALL`, `REG_CLR_FALL` and `REG_STAT`. There is no sequencing state. Every access completes in the cycle it is sampled.

## Requirements
- R1: Bank b (0..3) occupies ten word registers starting at byte address 0x10 + 0x28*b. Their offsets within the bank are: direction +0x00, output +0x04, set-output +0x08, clear-output +0x0C, input +0x10, set-rise +0x14, clear-rise +0x18, set-fall +0x1C, clear-fall +0x20, status +0x24. A read of any address outside the implemented banks, or of an address that is not word aligned, returns 0. A write to such an address changes nothing.
- R2: A direction bit of 1 makes the pin an input, and all direction bits reset to 1. `pin_oe` is the bitwise inverse of the direction register, so it is all zero after reset.
- R3: Writing a mask to set-output forces the masked output bits to 1 and leaves all other bits unchanged. From the next cycle, `pin_out` shows the new value.
- R4: Writing a mask to clear-output forces the masked output bits to 0 and leaves all other bits unchanged.
- R5: The output register can be written whole and reads back what was written. The set-output and clear-output aliases both read back the output register.
- R6: The input register returns the pin level for inputs and for driven outputs alike, through a two-flop synchronizer. After a pin changes, reads sampled at the first two clock edges return the old level. A read sampled at the third edge returns the new level.
- R7: The rising-edge and falling-edge enables are separate per-pin registers. Each is changed only through its own set alias and clear alias, and both aliases read back the enable register.
- R8: A 0-to-1 change of the synchronized level on a pin whose rising enable is set, or a 1-to-0 change on a pin whose falling enable is set, sets that pin's status bit. `irq[2b]` is the OR of bank b's status bits 15..0, and `irq[2b+1]` is the OR of its status bits 31..16.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new edge and a clear hit the same bit in the same cycle, the bit stays set.
- R10: Pins at or above `NUM_GPIO` have no register bits: those bits read 0 and ignore writes. A request line whose 16 pins are all absent stays 0. Every group with pins, including the groups above pin 80, can raise its line.
- R11: Read data is registered. `bus_rdata` takes the addressed value at the edge where a read is sampled, and holds that value through cycles that carry no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; also the pin sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, sampled at each rising edge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_GPIO | Asynchronous pin levels |
| pin_out | output | NUM_GPIO | Output latch values |
| pin_oe | output | NUM_GPIO | Per-pin drive enable, 1 = drive |
| irq | output | 2*ceil(NUM_GPIO/32) | One request line per 16-pin group |

## Verification
A corrupted output or direction bit shows on `pin_out` or `pin_oe` in the cycle after the offending write. An alias that writes the wrong bits shows up on the next readback of the output or enable register. A fault in the synchronizer depth or the edge detector shifts the cycle in which a status bit appears on `irq`. The bench therefore samples the request lines and the input register at exact edge counts after a pin change, and does not simply wait long enough. A status register that lets a clear beat a coincident edge loses the request line in the cycle after that collision.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BANK_BITS     = 32;
    localparam int MAX_BANKS     = 4;
    localparam int BANK_BASE     = 'h10;
    localparam int BANK_STRIDE   = 'h28;
    localparam int BANK_IDX_W    = 2;

    // Register kinds in address order inside one bank (word index 0..9)
    typedef enum logic [3:0] {
        REG_DIR      = 4'd0,
        REG_OUT      = 4'd1,
        REG_SET_OUT  = 4'd2,
        REG_CLR_OUT  = 4'd3,
        REG_IN       = 4'd4,
        REG_SET_RISE = 4'd5,
        REG_CLR_RISE = 4'd6,
        REG_SET_FALL = 4'd7,
        REG_CLR_FALL = 4'd8,
        REG_STAT     = 4'd9
    } gpio_reg_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit,
    output logic [BANK_IDX_W-1:0] bank,
    output gpio_reg_e             kind
);

    localparam int SPAN = NUM_BANKS * BANK_STRIDE;

    int off;

    always_comb begin
        off  = int'(addr) - BANK_BASE;
        hit  = (addr[1:0] == 2'b00) && (off >= 0) && (off < SPAN);
        bank = '0;
        kind = REG_DIR;
        if (hit) begin
            bank = BANK_IDX_W'(off / BANK_STRIDE);
            kind = gpio_reg_e'(4'((off % BANK_STRIDE) / 4));
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  gpio_reg_e     kind,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  pin_in,
    output logic [31:0]   rd_val,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic          irq_lo,
    output logic          irq_hi
);

    localparam int LO_W = (W < 16) ? W : 16;

    logic [W-1:0] dir_q, out_q, rise_q, fall_q, stat_q;
    logic [W-1:0] sync1_q, sync2_q, prev_q;
    logic [W-1:0] dir_d, out_d, rise_d, fall_d, stat_d;
    logic [W-1:0] clr_mask, edge_hit;

    // Register update from the bus
    always_comb begin
        dir_d    = dir_q;
        out_d    = out_q;
        rise_d   = rise_q;
        fall_d   = fall_q;
        clr_mask = '0;
        if (wr_en) begin
            unique case (kind)
                REG_DIR:      dir_d    = wdata;
                REG_OUT:      out_d    = wdata;
                REG_SET_OUT:  out_d    = out_q | wdata;
                REG_CLR_OUT:  out_d    = out_q & ~wdata;
                REG_IN:       ;
                REG_SET_RISE: rise_d   = rise_q | wdata;
                REG_CLR_RISE: rise_d   = rise_q & ~wdata;
                REG_SET_FALL: fall_d   = fall_q | wdata;
                REG_CLR_FALL: fall_d   = fall_q & ~wdata;
                REG_STAT:     clr_mask = wdata;
                default:      ;
            endcase
        end
    end

    // Edge detection on the synchronized level; new edges win over clears
    always_comb begin
        edge_hit = (sync2_q & ~prev_q & rise_q) | (~sync2_q & prev_q & fall_q);
        stat_d   = (stat_q & ~clr_mask) | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '1;
            out_q   <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            stat_q  <= '0;
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            dir_q   <= dir_d;
            out_q   <= out_d;
            rise_q  <= rise_d;
            fall_q  <= fall_d;
            stat_q  <= stat_d;
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // Read value for the addressed kind
    always_comb begin
        unique case (kind)
            REG_DIR:                   rd_val = 32'(dir_q);
            REG_OUT, REG_SET_OUT,
            REG_CLR_OUT:               rd_val = 32'(out_q);
            REG_IN:                    rd_val = 32'(sync2_q);
            REG_SET_RISE, REG_CLR_RISE: rd_val = 32'(rise_q);
            REG_SET_FALL, REG_CLR_FALL: rd_val = 32'(fall_q);
            REG_STAT:                  rd_val = 32'(stat_q);
            default:                   rd_val = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;
    assign irq_lo  = |stat_q[LO_W-1:0];

    generate
        if (W > 16) begin : g_hi
            assign irq_hi = |stat_q[W-1:16];
        end else begin : g_no_hi
            assign irq_hi = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_GPIO = 128,
    parameter int ADDR_W   = 8,
    localparam int NUM_BANKS = (NUM_GPIO + BANK_BITS - 1) / BANK_BITS,
    localparam int NUM_IRQ   = 2 * NUM_BANKS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_GPIO-1:0] pin_in,
    output logic [NUM_GPIO-1:0] pin_out,
    output logic [NUM_GPIO-1:0] pin_oe,
    output logic [NUM_IRQ-1:0]  irq
);

    logic                  dec_hit;
    logic [BANK_IDX_W-1:0] dec_bank;
    gpio_reg_e             dec_kind;
    logic [31:0]           bank_rd [NUM_BANKS];
    logic [31:0]           rd_sel;
    logic [31:0]           rdata_q;

    gpio_addr_dec #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr (bus_addr),
        .hit  (dec_hit),
        .bank (dec_bank),
        .kind (dec_kind)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam int LO = b * BANK_BITS;
            localparam int BW = ((NUM_GPIO - LO) >= BANK_BITS) ? BANK_BITS : (NUM_GPIO - LO);

            logic wr_sel;
            assign wr_sel = bus_en && bus_we && dec_hit && (dec_bank == BANK_IDX_W'(b));

            gpio_bank #(.W(BW)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wr_sel),
                .kind    (dec_kind),
                .wdata   (bus_wdata[BW-1:0]),
                .pin_in  (pin_in[LO +: BW]),
                .rd_val  (bank_rd[b]),
                .pin_out (pin_out[LO +: BW]),
                .pin_oe  (pin_oe[LO +: BW]),
                .irq_lo  (irq[2*b]),
                .irq_hi  (irq[2*b+1])
            );
        end
    endgenerate

    always_comb begin
        rd_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec_hit && (dec_bank == BANK_IDX_W'(b))) rd_sel = bank_rd[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rdata_q <= '0;
        else if (bus_en && !bus_we) rdata_q <= rd_sel;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int NUM_GPIO = 128,
    parameter int ADDR_W   = 8,
    localparam int NUM_BANKS = (NUM_GPIO + 31) / 32,
    localparam int NUM_IRQ   = 2 * NUM_BANKS
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_en,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [31:0]         out_lo,
    input logic [NUM_GPIO-1:0] pin_oe,
    input logic [NUM_IRQ-1:0]  irq
);

    localparam int SPAN = NUM_BANKS * 'h28;

    logic mapped;
    assign mapped = (bus_addr[1:0] == 2'b00) && (int'(bus_addr) >= 'h10)
                    && (int'(bus_addr) < 'h10 + SPAN);

    // R3: set-output alias on bank 0
    p_set_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == ADDR_W'('h18))
        |=> ((out_lo & $past(bus_wdata)) == $past(bus_wdata)));

    // R4: clear-output alias on bank 0
    p_clr_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == ADDR_W'('h1C))
        |=> ((out_lo & $past(bus_wdata)) == 32'h0));

    // R1: unmapped reads return zero
    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && !mapped) |=> (bus_rdata == 32'h0));

    // R2: no pin is driven straight after reset
    p_oe_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_oe == '0));

    // R9: a request line only drops after a bus write
    p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(irq) & ~irq)) |-> $past(bus_en && bus_we));

    // R11: read data holds without a read
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |=> $stable(bus_rdata));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
    .NUM_GPIO (NUM_GPIO),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .out_lo    (pin_out[31:0]),
    .pin_oe    (pin_oe),
    .irq       (irq)
);

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb;

    localparam int NG   = 104;
    localparam int NIRQ = 8;
    localparam int NV   = 22;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_en = 1'b0;
    logic            bus_we = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NG-1:0]   ext_pin = '0;
    logic [NG-1:0]   pin_in, pin_out, pin_oe;
    logic [NIRQ-1:0] irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_pin);

    gpio_bank_ctrl #(.NUM_GPIO(NG), .ADDR_W(8)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // {req[3:0], we, addr[7:0], wdata[31:0], expected[31:0]}
    localparam logic [76:0] VEC [NV] = '{
        {4'd2,  1'b0, 8'h10, 32'h0,        32'hFFFFFFFF}, // R2 reset direction
        {4'd5,  1'b1, 8'h14, 32'h12345678, 32'h0},        // R5
        {4'd5,  1'b0, 8'h14, 32'h0,        32'h12345678}, // R5
        {4'd3,  1'b1, 8'h18, 32'h0000FF00, 32'h0},        // R3
        {4'd3,  1'b0, 8'h1C, 32'h0,        32'h1234FF78}, // R3 and alias readback
        {4'd4,  1'b1, 8'h1C, 32'h12340000, 32'h0},        // R4
        {4'd4,  1'b0, 8'h18, 32'h0,        32'h0000FF78}, // R4
        {4'd10, 1'b1, 8'h9C, 32'hFFFFFFFF, 32'h0},        // R10 partial bank
        {4'd10, 1'b0, 8'h9C, 32'h0,        32'h000000FF}, // R10
        {4'd7,  1'b1, 8'h24, 32'h000000F0, 32'h0},        // R7
        {4'd7,  1'b1, 8'h28, 32'h00000030, 32'h0},        // R7
        {4'd7,  1'b0, 8'h24, 32'h0,        32'h000000C0}, // R7
        {4'd7,  1'b1, 8'h2C, 32'h00000003, 32'h0},        // R7
        {4'd7,  1'b0, 8'h30, 32'h0,        32'h00000003}, // R7
        {4'd1,  1'b0, 8'h0C, 32'h0,        32'h0},        // R1 below map
        {4'd1,  1'b1, 8'hB0, 32'hFFFFFFFF, 32'h0},        // R1 write past map
        {4'd1,  1'b0, 8'hB0, 32'h0,        32'h0},        // R1
        {4'd1,  1'b0, 8'h15, 32'h0,        32'h0},        // R1 misaligned
        {4'd1,  1'b1, 8'h3C, 32'hA5A5A5A5, 32'h0},        // R1 bank stride
        {4'd1,  1'b0, 8'h3C, 32'h0,        32'hA5A5A5A5}, // R1
        {4'd1,  1'b1, 8'h60, 32'h0000FFFF, 32'h0},        // R1
        {4'd1,  1'b0, 8'h60, 32'h0,        32'h0000FFFF}  // R1
    };

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R2 reset state at the ports
        check("R2 oe after reset", 128'(pin_oe), 128'h0);
        check("R8 irq after reset", 128'(irq), 128'h0);
        check("R3 out after reset", 128'(pin_out), 128'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) begin
                bus_write(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                bus_read(VEC[i][71:64], rd);
                check($sformatf("R%0d table %0d", VEC[i][76:73], i), 128'(rd), 128'(VEC[i][31:0]));
            end
        end

        // R2: drive low byte of bank 0; out = 0x78 so pin 6 rises (rise-enabled)
        bus_write(8'h10, 32'hFFFFFF00);
        check("R2 oe follows direction", 128'(pin_oe[7:0]), 128'hFF);
        idle(5);
        bus_read(8'h20, rd);
        check("R6 input reads driven level", 128'(rd), 128'h78);
        bus_read(8'h34, rd);
        check("R8 rising status", 128'(rd), 128'h40);
        check("R8 irq low half", 128'(irq[1:0]), 128'h1);
        bus_write(8'h34, 32'h40);
        check("R9 w1c clears irq", 128'(irq[0]), 128'h0);

        // R8 falling edge on pin 0
        bus_write(8'h18, 32'h1);
        idle(5);
        bus_read(8'h34, rd);
        check("R8 no status on unenabled rise", 128'(rd), 128'h0);
        bus_write(8'h1C, 32'h1);
        idle(5);
        bus_read(8'h34, rd);
        check("R8 falling status", 128'(rd), 128'h1);
        bus_write(8'h34, 32'h1);
        bus_read(8'h34, rd);
        check("R9 status cleared", 128'(rd), 128'h0);

        // R9 collision on pin 100 (bank 3 bit 4), group above pin 80 (R10)
        @(negedge clk);
        ext_pin[100] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'hAC; bus_wdata = 32'h10;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        check("R9 edge wins over clear", 128'(irq[6]), 128'h1);
        check("R10 absent group silent", 128'(irq[7]), 128'h0);
        bus_read(8'hAC, rd);
        check("R9 status after collision", 128'(rd), 128'h10);
        bus_write(8'hAC, 32'h10);
        check("R10 group line cleared", 128'(irq[6]), 128'h0);

        // R6 input lag on pin 40 (bank 1 bit 8)
        @(negedge clk);
        ext_pin[40] = 1'b1;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 8'h48;
        @(negedge clk);
        check("R6 first edge old level", 128'(bus_rdata[8]), 128'h0);
        @(negedge clk);
        check("R6 second edge old level", 128'(bus_rdata[8]), 128'h0);
        @(negedge clk);
        check("R6 third edge new level", 128'(bus_rdata[8]), 128'h1);
        bus_en = 1'b0;

        // R11 read data holds across a write and idle cycles
        rd = bus_rdata;
        bus_write(8'h14, 32'h0);
        idle(2);
        check("R11 rdata holds", 128'(bus_rdata), 128'(rd));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule